// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three identical 16-bit up-counters behind a small 16-bit register bus. Software loads a terminal count and a control word; while a channel is enabled it counts one step on each cycle where the shared tick-enable input is high. That input typically marks every fourth system clock. When a channel reaches its terminal count it latches a sticky flag and can raise a one-cycle interrupt request toward the system interrupt controller. It then either starts over from zero or halts, depending on its mode.

The enable bit is protected. A control write changes it only when an override bit is set in that same write, so software can update the other fields without stopping or starting a channel by accident. A terminal count of zero means a full period of 65536 ticks. The count and terminal-count registers can be rewritten while the channel runs, and the new value takes effect on the next tick.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every register of every channel reads 0 and `irqPulse` is all zeros.
- R2: An enabled channel advances its count by exactly one on each clock where `tickEn` is 1, and holds its count when `tickEn` is 0 or when it is disabled.
- R3: When a tick brings the count to the terminal count held in register 1, the count becomes 0 and control bit 5 (flag) reads 1. If control bit 13 (interrupt enable) is 1, `irqPulse[t]` is high for exactly the one cycle that follows that tick.
- R4: With control bit 0 (repeat) at 1 the channel keeps counting after it reaches the terminal count. With bit 0 at 0 the channel clears control bit 15 (enable) on reaching it, and later ticks leave the count at 0.
- R5: With control bit 13 at 0, reaching the terminal count sets the flag but gives no pulse on `irqPulse`.
- R6: A control write changes bit 15 (enable) only if bit 14 (override) is 1 in the same write. Otherwise enable keeps its value and the other fields are still updated.
- R7: Control bits 14, 12 to 6 and 4 to 1 always read 0, whatever value was written.
- R8: The flag stays set across further ticks and control writes that carry bit 5 at 1. A control write with bit 5 at 0 clears it.
- R9: A terminal count of 0 gives a period of 65536 ticks.
- R10: Writes to the count or to the terminal count of a running channel take effect on the very next tick.
- R11: Address map: `regAddr[3:2]` selects the channel, and `regAddr[1:0]` selects the register: 0 count, 1 terminal count, 2 spare count, 3 control. The spare count (register 2) reads back what was written and has no effect on counting. Channel index 3 reads 0. A write to one channel leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle count enable shared by all channels |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Channel index and register select |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Combinational read data for `regAddr` |
| irqPulse | output | 3 | Per-channel one-cycle interrupt request |

## Verification
A count register that skips or repeats a step shows up on the next register read and moves every later terminal-count event. The bench therefore checks both the count read back after a sweep and the number of request pulses it produced. A wrong enable state or stop decision is visible in the control readback one cycle after the offending tick, and as a count that either keeps moving or freezes. A lost or stray flag, or a request pulse on the wrong cycle, is caught at the tick that should or should not have produced it, because pulses are counted per tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_W = 16;

  // register select within a channel
  localparam logic [1:0] SEL_COUNT = 2'd0;
  localparam logic [1:0] SEL_TERM  = 2'd1;
  localparam logic [1:0] SEL_SPARE = 2'd2;
  localparam logic [1:0] SEL_CTRL  = 2'd3;

  // control word bit positions
  localparam int B_EN   = 15;
  localparam int B_OVR  = 14;
  localparam int B_IE   = 13;
  localparam int B_FLAG = 5;
  localparam int B_REP  = 0;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;
    logic wrCount;
    logic wrTerm;
    logic wrSpare;
  } tmr_strobe_t;

  // control-word fields extracted from a bus write
  typedef struct packed {
    logic en;
    logic ovr;
    logic ie;
    logic flag;
    logic rep;
  } ctl_fields_t;
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tmr_strobe_t      stb,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] count,
  output logic [REG_W-1:0] termCount,
  output logic [REG_W-1:0] spareCount,
  output logic             hit
);
  logic [REG_W-1:0] nextCount;

  // a terminal count of zero is reached by wrapping from all ones
  assign nextCount = count + 1'b1;
  assign hit       = stb.advance && (nextCount == termCount);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count      <= '0;
      termCount  <= '0;
      spareCount <= '0;
    end else begin
      if (stb.wrCount)      count <= wrData;
      else if (stb.advance) count <= hit ? '0 : nextCount;
      if (stb.wrTerm)  termCount  <= wrData;
      if (stb.wrSpare) spareCount <= wrData;
    end
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int MY_IDX = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             regWe,
  input  logic [IDX_W+1:0] regAddr,
  input  ctl_fields_t      wrFields,
  input  logic             hit,
  output tmr_strobe_t      stb,
  output logic [REG_W-1:0] ctrlWord,
  output logic             enOut,
  output logic             flagOut,
  output logic             irqPulse
);
  logic selMe, wrCtrl;
  logic en, ie, flag, rep;

  assign selMe  = regWe && (regAddr[IDX_W+1:2] == IDX_W'(MY_IDX));
  assign wrCtrl = selMe && (regAddr[1:0] == SEL_CTRL);

  always_comb begin
    stb.advance = en && tickEn;
    stb.wrCount = selMe && (regAddr[1:0] == SEL_COUNT);
    stb.wrTerm  = selMe && (regAddr[1:0] == SEL_TERM);
    stb.wrSpare = selMe && (regAddr[1:0] == SEL_SPARE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      en       <= 1'b0;
      ie       <= 1'b0;
      flag     <= 1'b0;
      rep      <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      irqPulse <= hit && ie;
      if (wrCtrl) begin
        ie   <= wrFields.ie;
        rep  <= wrFields.rep;
        flag <= wrFields.flag || hit;
        if (wrFields.ovr)   en <= wrFields.en;
        else if (hit && !rep) en <= 1'b0;
      end else if (hit) begin
        flag <= 1'b1;
        if (!rep) en <= 1'b0;
      end
    end
  end

  // override and held fields always read zero
  assign ctrlWord = {en, 1'b0, ie, 7'b0, flag, 4'b0, rep};
  assign enOut    = en;
  assign flagOut  = flag;
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tmr_pkg::*;
#(
  parameter int NUM_TIMERS = 3,
  localparam int IDX_W  = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tickEn,
  input  logic                  regWe,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [REG_W-1:0]      regWdata,
  output logic [REG_W-1:0]      regRdata,
  output logic [NUM_TIMERS-1:0] irqPulse
);
  ctl_fields_t wrFields;
  logic [NUM_TIMERS-1:0][REG_W-1:0] countVec, termVec, spareVec, ctrlVec;
  logic [NUM_TIMERS-1:0] enVec, flagVec;

  assign wrFields = '{en:   regWdata[B_EN],   ovr: regWdata[B_OVR],
                      ie:   regWdata[B_IE],   flag: regWdata[B_FLAG],
                      rep:  regWdata[B_REP]};

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_chan
    tmr_strobe_t stb;
    logic        hit;

    tmr_ctrl #(.IDX_W(IDX_W), .MY_IDX(g)) u_ctrl (
      .clk      (clk),
      .rstN     (rstN),
      .tickEn   (tickEn),
      .regWe    (regWe),
      .regAddr  (regAddr),
      .wrFields (wrFields),
      .hit      (hit),
      .stb      (stb),
      .ctrlWord (ctrlVec[g]),
      .enOut    (enVec[g]),
      .flagOut  (flagVec[g]),
      .irqPulse (irqPulse[g])
    );

    tmr_datapath u_dp (
      .clk        (clk),
      .rstN       (rstN),
      .stb        (stb),
      .wrData     (regWdata),
      .count      (countVec[g]),
      .termCount  (termVec[g]),
      .spareCount (spareVec[g]),
      .hit        (hit)
    );
  end

  always_comb begin
    regRdata = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (regAddr[ADDR_W-1:2] == IDX_W'(i)) begin
        case (regAddr[1:0])
          SEL_COUNT: regRdata = countVec[i];
          SEL_TERM:  regRdata = termVec[i];
          SEL_SPARE: regRdata = spareVec[i];
          default:   regRdata = ctrlVec[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/tick_timer_bank_chk.sv
module tick_timer_bank_chk
  import tmr_pkg::*;
#(
  parameter int NUM_TIMERS = 3,
  localparam int IDX_W  = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
  localparam int ADDR_W = IDX_W + 2
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              regWe,
  input logic [ADDR_W-1:0]                 regAddr,
  input logic [REG_W-1:0]                  regWdata,
  input logic [REG_W-1:0]                  regRdata,
  input logic [NUM_TIMERS-1:0]             irqPulse,
  input logic [NUM_TIMERS-1:0][REG_W-1:0]  countVec,
  input logic [NUM_TIMERS-1:0]             enVec,
  input logic [NUM_TIMERS-1:0]             flagVec
);
  // R7
  ctrl_zero_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr[1:0] == SEL_CTRL) |-> (regRdata[14] == 1'b0 && regRdata[12:6] == 7'b0 && regRdata[4:1] == 4'b0));

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chk
    // R2
    idle_count_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!enVec[i] && !(regWe && regAddr == {IDX_W'(i), SEL_COUNT})) |=> $stable(countVec[i]));
    // R3
    pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
      irqPulse[i] |-> flagVec[i]);
    // R3
    pulse_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
      irqPulse[i] |-> $past(enVec[i]));
    // R3
    pulse_count_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      (irqPulse[i] && !$past(regWe)) |-> (countVec[i] == '0));
    // R6
    en_rise_needs_ovr_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(enVec[i]) |-> $past(regWe && regWdata[B_OVR] && regWdata[B_EN]));
  end
endmodule

bind tick_timer_bank tick_timer_bank_chk #(.NUM_TIMERS(NUM_TIMERS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWe    (regWe),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .regRdata (regRdata),
  .irqPulse (irqPulse),
  .countVec (countVec),
  .enVec    (enVec),
  .flagVec  (flagVec)
);

// File: tb/tb_tick_timer_bank.sv
module tb_tick_timer_bank;
  localparam logic [15:0] EN = 16'h8000, OVR = 16'h4000, IE = 16'h2000,
                          FLG = 16'h0020, REP = 16'h0001;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic [2:0]  irqPulse;

  int checks = 0;
  int errors = 0;
  int pulses = 0;

  always #2 clk = ~clk;

  tick_timer_bank dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irqPulse(irqPulse)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int t, int r, logic [15:0] d);
    @(negedge clk);
    regAddr = {2'(t), 2'(r)};
    regWdata = d;
    regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(int t, int r, output logic [15:0] d);
    @(negedge clk);
    regAddr = {2'(t), 2'(r)};
    #1 d = regRdata;
  endtask

  task automatic tick(int t);
    @(negedge clk);
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    if (irqPulse[t]) pulses++;
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int t = 0; t < 3; t++)
      for (int r = 0; r < 4; r++) begin
        rd(t, r, d);
        chk("R1 reset reg", d, 0);
      end
    chk("R1 irq idle", irqPulse, 0);

    // R7 ignored bits
    wr(0, 3, 16'h5FDE);
    rd(0, 3, d); chk("R7 ctrl ignored bits", d, 0);
    wr(2, 3, 16'hFFFF);
    rd(2, 3, d); chk("R7 ctrl full write", d, EN | IE | FLG | REP);
    wr(2, 3, OVR);
    rd(2, 3, d); chk("R7 ctrl cleared", d, 0);

    // R6 enable guarded by override
    wr(0, 1, 16'd100);
    wr(0, 3, EN);
    rd(0, 3, d); chk("R6 enable without override", d, 0);
    tick(0); tick(0);
    rd(0, 0, d); chk("R6 disabled no count", d, 0);
    wr(0, 3, EN | OVR | REP);
    tick(0); tick(0);
    rd(0, 0, d); chk("R2 two ticks", d, 2);
    // R2 no tickEn, no count
    repeat (10) @(negedge clk);
    rd(0, 0, d); chk("R2 idle tickEn", d, 2);
    wr(0, 3, 16'h0000);
    rd(0, 3, d); chk("R6 disable without override", d, EN);
    tick(0);
    rd(0, 0, d); chk("R6 still running", d, 3);
    wr(0, 3, OVR);

    // R10 count write while running
    wr(0, 1, 16'd8);
    wr(0, 0, 16'd5);
    wr(0, 3, EN | OVR | IE | REP);
    pulses = 0;
    tick(0); tick(0);
    chk("R10 no early pulse", pulses, 0);
    tick(0);
    chk("R10 pulse after count write", pulses, 1);
    rd(0, 0, d); chk("R3 wrapped to zero", d, 0);
    tick(0); tick(0);
    wr(0, 1, 16'd4);
    pulses = 0;
    tick(0);
    chk("R10 term write no pulse yet", pulses, 0);
    tick(0);
    chk("R10 term write pulse", pulses, 1);

    // R8 sticky flag
    tick(0);
    rd(0, 3, d); chk("R8 flag sticky", d, EN | IE | FLG | REP);
    wr(0, 3, IE | FLG | REP);
    rd(0, 3, d); chk("R8 flag kept by write", d, EN | IE | FLG | REP);
    wr(0, 3, IE | REP);
    rd(0, 3, d); chk("R8 flag cleared", d, EN | IE | REP);
    wr(0, 3, OVR);

    // R5 no pulse when interrupt disabled
    wr(2, 1, 16'd2);
    wr(2, 0, 16'd0);
    wr(2, 3, EN | OVR | REP);
    pulses = 0;
    tick(2); tick(2);
    chk("R5 no pulse", pulses, 0);
    rd(2, 3, d); chk("R5 flag set", d, EN | FLG | REP);
    wr(2, 3, OVR);

    // R11 spare register, independence, unused index
    for (int t = 0; t < 3; t++) wr(t, 2, 16'hA5A0 + 16'(t));
    for (int t = 0; t < 3; t++) begin
      rd(t, 2, d); chk("R11 spare readback", d, 16'hA5A0 + 16'(t));
    end
    wr(0, 0, 16'h0033);
    wr(1, 0, 16'h1234);
    rd(0, 0, d); chk("R11 channel independence", d, 16'h0033);
    rd(3, 0, d); chk("R11 unused index", d, 0);
    wr(1, 1, 16'd3);
    wr(1, 0, 16'd0);
    wr(1, 3, EN | OVR | IE | REP);
    pulses = 0;
    repeat (6) tick(1);
    chk("R11 spare no effect", pulses, 2);
    wr(1, 3, OVR);

    // R2 R3 R4 sweep
    for (int t = 0; t < 3; t++)
      for (int m = 1; m <= 6; m++)
        for (int c = 0; c < 2; c++) begin
          int nt;
          nt = 2 * m + 1;
          wr(t, 1, 16'(m));
          wr(t, 0, 16'd0);
          wr(t, 3, EN | OVR | IE | 16'(c));
          pulses = 0;
          repeat (nt) tick(t);
          chk("R3 sweep pulses", pulses, (c != 0) ? nt / m : 1);
          rd(t, 0, d); chk("R2 sweep count", d, (c != 0) ? nt % m : 0);
          rd(t, 3, d); chk("R4 sweep ctrl", d, (c != 0) ? (EN | IE | FLG | REP) : (IE | FLG));
          wr(t, 3, OVR);
        end

    // R9 full period
    wr(1, 1, 16'd0);
    wr(1, 0, 16'd0);
    wr(1, 3, EN | OVR | IE | REP);
    pulses = 0;
    @(negedge clk);
    tickEn = 1'b1;
    repeat (65535) begin
      @(negedge clk);
      if (irqPulse[1]) pulses++;
    end
    tickEn = 1'b0;
    chk("R9 no pulse before 65536", pulses, 0);
    rd(1, 0, d); chk("R9 count all ones", d, 16'hFFFF);
    tick(1);
    chk("R9 pulse at 65536", pulses, 1);
    rd(1, 0, d); chk("R9 wrapped", d, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule